// File: doc/BRIEF.md
# Memory Wait-Cycle Inserter

This block stretches processor memory cycles so that slow memory has time to respond. It watches the processor's memory-request strobe and drives an active-low wait request back to the processor. Each wait cycle lasts one processor clock period. The real time of a wait cycle therefore follows the clock rate the system runs at. At 4 MHz one wait cycle is 250 ns, and at 2 MHz it is 500 ns.

Two kinds of stretching are set up separately, and both may be used at once. The first kind is a general count of zero to three wait cycles. It applies to every memory cycle. The second kind is a single extra wait cycle. It applies only to opcode-fetch cycles, and only when it is selected.

The memory-request strobe is asserted only for memory cycles, so I/O cycles receive no inserted waits. A ready input from the bus is merged into the wait request, so a slow device can hold the cycle open for longer. The block does not decode memory addresses and does not generate the clock.

Top module: `memwait_gen`

## Requirements
- R1: While reset is active, and afterwards while `mem_req` is low, `wait_n` is high.
- R2: A memory cycle with `fetch` low receives exactly as many wait cycles as the unsigned value of `gen_waits` (0 to 3). A wait cycle is a rising clock edge at which `wait_n` is low.
- R3: A memory cycle with `fetch` high receives one wait cycle more than the `gen_waits` value when `fetch_wait_en` is 1. It receives no extra wait cycle when `fetch_wait_en` is 0.
- R4: `fetch_wait_en` has no effect on a memory cycle whose `fetch` is low.
- R5: When both kinds of wait are active, the number of wait cycles is their sum. With the default parameters that sum is at most 4.
- R6: When the total for a cycle is nonzero, `wait_n` goes low in the same clock period in which `mem_req` first rises, before the first sampling edge.
- R7: When `gen_waits` is 0 and no fetch extra applies, no wait cycle is inserted.
- R8: The values of `gen_waits`, `fetch_wait_en` and `fetch` are taken only in the first clock period of a request. Changes to them later in the same request have no effect.
- R9: While `mem_req` is high and `bus_ready` is low, `wait_n` is low. This extends a cycle beyond its programmed count. While `mem_req` is low, `bus_ready` has no effect and `wait_n` stays high.
- R10: Each new request, recognised by `mem_req` rising after at least one low clock period, receives its full programmed count. Any count left over from a request that ended early is discarded.
- R11: Once `wait_n` has gone high within a request, it stays high for the rest of that request while `bus_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| mem_req | input | 1 | High for the whole of a memory machine cycle |
| fetch | input | 1 | High when the current cycle is an opcode fetch |
| gen_waits | input | GEN_W (2) | Wait cycles added to every memory cycle |
| fetch_wait_en | input | 1 | Selects the extra wait on opcode fetches |
| bus_ready | input | 1 | High when the bus allows the cycle to finish |
| wait_n | output | 1 | Active-low wait request to the processor |

## Verification
The hardest case to reach is a request that ends while wait cycles are still pending, followed at once by a new request. Only that sequence shows whether the leftover count is thrown away. The stimulus reaches it by dropping the strobe after two of four waits, leaving one idle clock period, and then issuing a full-length request. A second hard case is a configuration change in the middle of a request. The stimulus covers it by inverting the count and the fetch selector one clock period after the cycle starts. It then compares the number of waits seen against the count in force at the start.

// File: rtl/memwait_pkg.sv
`timescale 1ns/1ps
package memwait_pkg;

   // where the current clock period sits within a memory request
   typedef enum logic [1:0] {
      REQ_IDLE  = 2'd0,
      REQ_FIRST = 2'd1,
      REQ_LATER = 2'd2
   } req_phase_e;

   // largest wait total reachable from the configuration inputs
   function automatic int unsigned max_total(input int unsigned gen_w,
                                             input int unsigned fetch_extra);
      return ((1 << gen_w) - 1) + fetch_extra;
   endfunction

   // counter width able to hold max_total
   function automatic int unsigned cnt_width(input int unsigned gen_w,
                                             input int unsigned fetch_extra);
      int unsigned w;
      w = $clog2(max_total(gen_w, fetch_extra) + 1);
      return (w < 1) ? 1 : w;
   endfunction

endpackage

// File: rtl/memwait_start_det.sv
`timescale 1ns/1ps
module memwait_start_det
   import memwait_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mem_req,
   output req_phase_e phase
);

   logic req_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else begin
         req_q <= mem_req;
      end
   end

   always_comb begin
      if (!mem_req) begin
         phase = REQ_IDLE;
      end else if (!req_q) begin
         phase = REQ_FIRST;
      end else begin
         phase = REQ_LATER;
      end
   end

endmodule

// File: rtl/memwait_budget.sv
`timescale 1ns/1ps
module memwait_budget #(
   parameter int unsigned GEN_W       = 2,
   parameter int unsigned FETCH_EXTRA = 1,
   parameter int unsigned CNT_W       = 3
) (
   input  logic [GEN_W-1:0] gen_cfg,
   input  logic             fetch,
   input  logic             fetch_en,
   output logic [CNT_W-1:0] total
);

   logic [CNT_W-1:0] gen_part;
   logic [CNT_W-1:0] extra_part;

   assign gen_part = CNT_W'(gen_cfg);

   generate
      if (FETCH_EXTRA == 0) begin : g_no_extra
         logic unused_sel;
         assign unused_sel = fetch ^ fetch_en;
         assign extra_part = '0;
      end else begin : g_extra
         assign extra_part = (fetch && fetch_en) ? CNT_W'(FETCH_EXTRA) : '0;
      end
   endgenerate

   assign total = gen_part + extra_part;

endmodule

// File: rtl/memwait_counter.sv
`timescale 1ns/1ps
module memwait_counter
   import memwait_pkg::*;
#(
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  req_phase_e       phase,
   input  logic [CNT_W-1:0] total,
   output logic             busy
);

   logic [CNT_W-1:0] remain_q;

   // first period uses the fresh total, later periods the stored remainder
   always_comb begin
      unique case (phase)
         REQ_FIRST: busy = (total != '0);
         REQ_LATER: busy = (remain_q != '0);
         default:   busy = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else begin
         unique case (phase)
            REQ_FIRST: remain_q <= (total != '0) ? total - 1'b1 : '0;
            REQ_LATER: begin
               if (remain_q != '0) begin
                  remain_q <= remain_q - 1'b1;
               end
            end
            default:   remain_q <= '0;
         endcase
      end
   end

endmodule

// File: rtl/memwait_gen.sv
`timescale 1ns/1ps
module memwait_gen
   import memwait_pkg::*;
#(
   parameter int unsigned GEN_W       = 2,
   parameter int unsigned FETCH_EXTRA = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mem_req,
   input  logic             fetch,
   input  logic [GEN_W-1:0] gen_waits,
   input  logic             fetch_wait_en,
   input  logic             bus_ready,
   output logic             wait_n
);

   localparam int unsigned CNT_W = cnt_width(GEN_W, FETCH_EXTRA);

   generate
      if (GEN_W < 1 || GEN_W > 6) begin : g_bad_gen_w
         $error("memwait_gen: GEN_W out of range");
      end
      if (FETCH_EXTRA > 15) begin : g_bad_extra
         $error("memwait_gen: FETCH_EXTRA out of range");
      end
   endgenerate

   req_phase_e       phase;
   logic [CNT_W-1:0] total;
   logic             cnt_busy;
   logic             ext_hold;

   memwait_start_det u_start (
      .clk     (clk),
      .rst_n   (rst_n),
      .mem_req (mem_req),
      .phase   (phase)
   );

   memwait_budget #(
      .GEN_W       (GEN_W),
      .FETCH_EXTRA (FETCH_EXTRA),
      .CNT_W       (CNT_W)
   ) u_budget (
      .gen_cfg  (gen_waits),
      .fetch    (fetch),
      .fetch_en (fetch_wait_en),
      .total    (total)
   );

   memwait_counter #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (phase),
      .total (total),
      .busy  (cnt_busy)
   );

   assign ext_hold = mem_req && !bus_ready;
   assign wait_n   = !(cnt_busy || ext_hold);

endmodule

// File: rtl/memwait_gen_chk.sv
`timescale 1ns/1ps
module memwait_gen_chk
   import memwait_pkg::*;
#(
   parameter int unsigned GEN_W       = 2,
   parameter int unsigned FETCH_EXTRA = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mem_req,
   input logic             fetch,
   input logic [GEN_W-1:0] gen_waits,
   input logic             fetch_wait_en,
   input logic             bus_ready,
   input logic             wait_n
);

   localparam int unsigned MAX_T = max_total(GEN_W, FETCH_EXTRA);

   logic       prev_req;
   logic       prev_wait_n;
   logic       rdy_low_seen;
   logic [7:0] streak;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_req     <= 1'b0;
         prev_wait_n  <= 1'b1;
         rdy_low_seen <= 1'b0;
         streak       <= '0;
      end else begin
         prev_req    <= mem_req;
         prev_wait_n <= wait_n;
         if (!mem_req) begin
            rdy_low_seen <= 1'b0;
            streak       <= '0;
         end else begin
            if (!bus_ready) rdy_low_seen <= 1'b1;
            if (!wait_n && streak != 8'hFF) streak <= streak + 1'b1;
         end
      end
   end

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req |-> wait_n); // R9

   AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !bus_ready) |-> !wait_n); // R9

   AST_ZERO_CFG_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !prev_req && gen_waits == '0 && !(fetch && fetch_wait_en) && bus_ready)
         |-> wait_n); // R7

   AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !wait_n && bus_ready && !rdy_low_seen) |-> (streak < 8'(MAX_T))); // R5

   AST_NO_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && prev_req && prev_wait_n && bus_ready) |-> wait_n); // R11

endmodule

bind memwait_gen memwait_gen_chk #(
   .GEN_W       (GEN_W),
   .FETCH_EXTRA (FETCH_EXTRA)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mem_req       (mem_req),
   .fetch         (fetch),
   .gen_waits     (gen_waits),
   .fetch_wait_en (fetch_wait_en),
   .bus_ready     (bus_ready),
   .wait_n        (wait_n)
);

// File: tb/memwait_gen_tb.sv
`timescale 1ns/1ps
module memwait_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       mem_req;
   logic       fetch;
   logic [1:0] gen_waits;
   logic       fetch_wait_en;
   logic       bus_ready;
   logic       wait_n;

   int    total_chk = 0;
   int    bad_chk   = 0;
   int    exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   memwait_gen dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .mem_req       (mem_req),
      .fetch         (fetch),
      .gen_waits     (gen_waits),
      .fetch_wait_en (fetch_wait_en),
      .bus_ready     (bus_ready),
      .wait_n        (wait_n)
   );

   function automatic void check(input bit ok, input string tag,
                                 input int act, input int exp);
      total_chk++;
      if (!ok) begin
         bad_chk++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endfunction

   // monitor: counts wait cycles per request, then compares with the scoreboard
   initial begin
      int lows;
      bit in_req;
      int e;
      string t;
      lows   = 0;
      in_req = 1'b0;
      forever begin
         @(negedge clk);
         #1.5;
         if (rst_n && mem_req) begin
            in_req = 1'b1;
            if (!wait_n) lows++;
         end else if (in_req) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R10 unexpected request", lows, -1);
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(lows == e, t, lows, e);
            end
            in_req = 1'b0;
            lows   = 0;
         end
      end
   end

   // driver: one memory request; pushes the expected wait count
   task automatic do_req(input logic [1:0] g, input logic e, input logic f,
                         input int rdy_low, input int abort_at, input bit cfg_flip,
                         input int exp, input string tag);
      int  n;
      bit  w;
      n = 0;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      gen_waits     = g;
      fetch_wait_en = e;
      fetch         = f;
      bus_ready     = (rdy_low == 0);
      mem_req       = 1'b1;
      forever begin
         #1.5;
         w = wait_n;
         if (n == 0) check(w == (exp == 0), "R6 first-period wait", int'(w), int'(exp == 0));
         if (w || n > 20) break;
         n++;
         @(negedge clk);
         if (abort_at != 0 && n == abort_at) begin
            mem_req = 1'b0;
            return;
         end
         bus_ready = (n >= rdy_low);
         if (cfg_flip) begin
            gen_waits     = ~g;
            fetch_wait_en = ~e;
         end
      end
      @(negedge clk);
      #1.5;
      check(wait_n == 1'b1, "R11 stays released", int'(wait_n), 1);
      @(negedge clk);
      mem_req = 1'b0;
   endtask

   initial begin
      #1_000_000;
      bad_chk++;
      total_chk++;
      $display("FAIL watchdog expired actual=hang expected=done");
      $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
   end

   initial begin
      string tg;
      rst_n         = 1'b0;
      mem_req       = 1'b0;
      fetch         = 1'b0;
      gen_waits     = 2'd3;
      fetch_wait_en = 1'b1;
      bus_ready     = 1'b1;
      repeat (2) @(negedge clk);
      #1.5;
      check(wait_n == 1'b1, "R1 in reset", int'(wait_n), 1);
      @(negedge clk);
      rst_n = 1'b1;
      #1.5;
      check(wait_n == 1'b1, "R1 after reset", int'(wait_n), 1);

      // every configuration for fetch and non-fetch cycles
      for (int g = 0; g < 4; g++) begin
         for (int e = 0; e < 2; e++) begin
            for (int f = 0; f < 2; f++) begin
               if (g == 0 && !(f == 1 && e == 1)) tg = "R7 zero config";
               else if (f == 0 && e == 1)         tg = "R4 fetch select ignored";
               else if (f == 0)                   tg = "R2 general count";
               else if (e == 1 && g != 0)         tg = "R5 combined total";
               else                               tg = "R3 fetch extra";
               do_req(2'(g), 1'(e), 1'(f), 0, 0, 1'b0, g + ((f == 1 && e == 1) ? 1 : 0), tg);
            end
         end
      end

      // configuration changed mid-request
      do_req(2'd1, 1'b0, 1'b1, 0, 0, 1'b1, 1, "R8 late config change");
      do_req(2'd3, 1'b1, 1'b1, 0, 0, 1'b1, 4, "R8 late config change");

      // bus ready extends cycles
      do_req(2'd1, 1'b0, 1'b0, 3, 0, 1'b0, 3, "R9 ready extends");
      do_req(2'd0, 1'b0, 1'b0, 2, 0, 1'b0, 2, "R9 ready extends");
      @(negedge clk);
      bus_ready = 1'b0;
      #1.5;
      check(wait_n == 1'b1, "R9 ready ignored when idle", int'(wait_n), 1);
      @(negedge clk);
      bus_ready = 1'b1;

      // abandoned request, then a fresh one
      do_req(2'd3, 1'b1, 1'b1, 0, 2, 1'b0, 2, "R10 abandoned request");
      do_req(2'd3, 1'b1, 1'b1, 0, 0, 1'b0, 4, "R10 reload after abandon");
      do_req(2'd2, 1'b0, 1'b0, 0, 0, 1'b0, 2, "R10 reload");

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
   end

endmodule